// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers up to 64 level-sensitive device interrupt lines into one raw request register. Each of four processors owns a 64-bit enable mask. A processor's device-interrupt output is raised whenever any raw request that its mask enables is pending. A separate input carries the cascade output of the legacy interrupt controller, and it is folded into line 55.

Software reaches the block through a small register port. A request is presented for one cycle with `req_valid`. The port never applies back-pressure: every request is accepted in the cycle it is presented. Exactly one cycle later, `rsp_valid` returns with the read data and an error flag. There is no ready signal on either side, so the consumer of the response must take it in the cycle it appears. Only full 8-byte accesses are legal.

Top module: `dev_irq_router`

## Requirements
- R1: The raw request register is loaded on every clock edge with the level of each `dev_lines` bit, so bit n is 1 exactly while line n was high at the previous edge.
- R2: `cpu_irq[c]` is registered. After each edge it equals 1 when the mask of processor c ANDed with the raw register, as both stood before that edge, is non-zero.
- R3: A full-size write to offset 0x200, 0x240, 0x600 or 0x640 stores all 64 bits of `req_wdata` as the mask of processor 0, 1, 2 or 3. A read of the same offset returns the stored mask.
- R4: A full-size read of offset 0x280, 0x2C0, 0x680 or 0x6C0 returns the mask of processor 0, 1, 2 or 3 ANDed with the raw register.
- R5: A full-size read of offset 0x300 returns the raw register. Writes to 0x300 and to the four masked-view offsets change nothing and complete without error.
- R6: When `legacy_cascade` is high, raw bit 55 is set at the next edge, whatever the level of `dev_lines[55]`.
- R7: A request with `req_size` other than 3 (8 bytes) returns `rsp_err`=1 and all-ones data. Such a write changes no mask.
- R8: A request to any offset not listed in R3 to R5 returns `rsp_err`=1 and all-ones data. Such a write changes nothing.
- R9: While `rst_n` is low at a clock edge, all masks, the raw register, `cpu_irq`, and `rsp_valid` clear to zero.
- R10: `rsp_valid` is high exactly one cycle after each accepted request. A read returns the state from before that request's own edge, and a legal write responds with zero data and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_lines | input | 64 | Level-sensitive device interrupt lines |
| legacy_cascade | input | 1 | Cascade output of the legacy interrupt controller, routed to line 55 |
| req_valid | input | 1 | Register request present (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| req_size | input | 3 | log2 of access size in bytes; only 3 is legal |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 64 | Read data, zero for a legal write, all ones on error |
| rsp_err | output | 1 | Illegal size or unmapped offset |
| cpu_irq | output | 4 | Device interrupt per processor |

## Verification
On every cycle, the embedded properties check the following: each processor output tracks its masked request one edge later, the cascade input lands on line 55, every request gets its response one cycle later, errored responses carry all ones, an illegal size is flagged, and at most one mask is written at a time. Only the bench scenarios can show three further points. The first is that stored masks and masked views read back with the right values at the right offsets. The second is that writes to read-only or unmapped offsets and undersized writes leave every register untouched. The third is that a read returns the state from before the edge that served it.

// File: rtl/dev_irq_router_pkg.sv
package dev_irq_router_pkg;
  localparam int unsigned MAX_CPU   = 4;
  localparam logic [11:0] RAW_OFS   = 12'h300;
  localparam logic [11:0] VIEW_STEP = 12'h080;

  // Mask offsets: bit 0 of the CPU index selects +0x40, bit 1 selects +0x400.
  function automatic logic [11:0] mask_ofs(input int unsigned cpu);
    logic [11:0] o;
    o = 12'h200;
    if ((cpu & 1) != 0) o = o | 12'h040;
    if ((cpu & 2) != 0) o = o | 12'h400;
    return o;
  endfunction

  function automatic logic [11:0] view_ofs(input int unsigned cpu);
    return mask_ofs(cpu) + VIEW_STEP;
  endfunction
endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
  parameter int unsigned LINES        = 64,
  parameter int unsigned CASCADE_LINE = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] dev_lines,
  input  logic             cascade,
  output logic [LINES-1:0] raw_q
);
  logic [LINES-1:0] merged;

  always_comb begin
    merged = dev_lines;
    merged[CASCADE_LINE] = dev_lines[CASCADE_LINE] | cascade;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= merged;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned LINES   = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CPU-1:0]              wr_en,
  input  logic [LINES-1:0]                wdata,
  output logic [NUM_CPU-1:0][LINES-1:0]   mask_q
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)        mask_q[c] <= '0;
      else if (wr_en[c]) mask_q[c] <= wdata;
    end
  end
endmodule

// File: rtl/irq_cpu_out.sv
module irq_cpu_out #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned LINES   = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CPU-1:0][LINES-1:0] mask_q,
  input  logic [LINES-1:0]              raw_q,
  output logic [NUM_CPU-1:0]            cpu_irq
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) cpu_irq[c] <= 1'b0;
      else        cpu_irq[c] <= |(mask_q[c] & raw_q);
    end
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import dev_irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned LINES     = 64,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned FULL_SIZE = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic [NUM_CPU-1:0][LINES-1:0] mask_q,
  input  logic [LINES-1:0]              raw_q,
  output logic [NUM_CPU-1:0]            wr_en,
  output logic                          rsp_valid,
  output logic [LINES-1:0]              rsp_rdata,
  output logic                          rsp_err
);
  logic             size_ok;
  logic             mapped;
  logic [LINES-1:0] rd_val;

  assign size_ok = (req_size == SIZE_W'(FULL_SIZE));

  always_comb begin
    mapped = 1'b0;
    rd_val = '0;
    wr_en  = '0;
    if (req_addr == ADDR_W'(RAW_OFS)) begin
      mapped = 1'b1;
      rd_val = raw_q;
    end
    for (int c = 0; c < NUM_CPU; c++) begin
      if (req_addr == ADDR_W'(mask_ofs(c))) begin
        mapped   = 1'b1;
        rd_val   = mask_q[c];
        wr_en[c] = req_valid && req_write && size_ok;
      end
      if (req_addr == ADDR_W'(view_ofs(c))) begin
        mapped = 1'b1;
        rd_val = mask_q[c] & raw_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !(size_ok && mapped);
      if (!req_valid)               rsp_rdata <= '0;
      else if (!(size_ok && mapped)) rsp_rdata <= '1;
      else if (req_write)           rsp_rdata <= '0;
      else                          rsp_rdata <= rd_val;
    end
  end

  p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_err_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '1));
  p_bad_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_ok) |=> rsp_err);
  p_single_mask_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router #(
  parameter int unsigned NUM_CPU      = 4,
  parameter int unsigned LINES        = 64,
  parameter int unsigned CASCADE_LINE = 55,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned SIZE_W       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   dev_lines,
  input  logic               legacy_cascade,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LINES-1:0]   req_wdata,
  input  logic [SIZE_W-1:0]  req_size,
  output logic               rsp_valid,
  output logic [LINES-1:0]   rsp_rdata,
  output logic               rsp_err,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int unsigned FULL_SIZE = $clog2(LINES / 8);

  logic [LINES-1:0]              raw_q;
  logic [NUM_CPU-1:0][LINES-1:0] mask_q;
  logic [NUM_CPU-1:0]            wr_en;

  irq_raw_capture #(.LINES(LINES), .CASCADE_LINE(CASCADE_LINE)) u_raw (
    .clk(clk), .rst_n(rst_n), .dev_lines(dev_lines),
    .cascade(legacy_cascade), .raw_q(raw_q));

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .LINES(LINES)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(req_wdata), .mask_q(mask_q));

  irq_cpu_out #(.NUM_CPU(NUM_CPU), .LINES(LINES)) u_out (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .raw_q(raw_q), .cpu_irq(cpu_irq));

  irq_reg_port #(.NUM_CPU(NUM_CPU), .LINES(LINES), .ADDR_W(ADDR_W),
                 .SIZE_W(SIZE_W), .FULL_SIZE(FULL_SIZE)) u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .mask_q(mask_q), .raw_q(raw_q),
    .wr_en(wr_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] == $past(|(mask_q[c] & raw_q)));
  end

  p_cascade_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_cascade |=> raw_q[CASCADE_LINE]);
endmodule

// File: tb/dev_irq_router_test.sv
module dev_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dev_lines = '0;
  logic        legacy_cascade = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [2:0]  req_size = 3'd3;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  cpu_irq;

  always #5 clk = ~clk;

  dev_irq_router uut (
    .clk(clk), .rst_n(rst_n), .dev_lines(dev_lines), .legacy_cascade(legacy_cascade),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cpu_irq(cpu_irq));

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;
  logic [3:0]  e_irq;
  logic        e_valid, e_err;
  logic [63:0] e_data;
  string       e_tag, irq_tag;
  bit          model_ready = 0;
  int          kind, cpu_sel;

  task automatic decode(input logic [11:0] a, output int k, output int c);
    k = 0; c = 0;
    case (a)
      12'h200: begin k = 1; c = 0; end
      12'h240: begin k = 1; c = 1; end
      12'h600: begin k = 1; c = 2; end
      12'h640: begin k = 1; c = 3; end
      12'h280: begin k = 2; c = 0; end
      12'h2C0: begin k = 2; c = 1; end
      12'h680: begin k = 2; c = 2; end
      12'h6C0: begin k = 2; c = 3; end
      12'h300: k = 3;
      default: k = 0;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
      m_raw = '0; e_irq = '0; e_valid = 0; e_err = 0; e_data = '0;
      e_tag = "R9"; irq_tag = "R9"; model_ready = 1;
    end else begin
      irq_tag = "R2";
      for (int c = 0; c < 4; c++) e_irq[c] = |(m_mask[c] & m_raw);
      e_valid = req_valid; e_err = 0; e_data = '0; e_tag = "R10";
      if (req_valid) begin
        decode(req_addr, kind, cpu_sel);
        if (req_size != 3'd3) begin
          e_err = 1; e_data = '1; e_tag = "R7";
        end else if (kind == 0) begin
          e_err = 1; e_data = '1; e_tag = "R8";
        end else if (req_write) begin
          e_tag = "R10";
          if (kind == 1) m_mask[cpu_sel] = req_wdata;
        end else if (kind == 1) begin
          e_data = m_mask[cpu_sel]; e_tag = "R3";
        end else if (kind == 2) begin
          e_data = m_mask[cpu_sel] & m_raw; e_tag = "R4";
        end else begin
          e_data = m_raw; e_tag = "R1 R5 R6";
        end
      end
      m_raw = dev_lines;
      if (legacy_cascade) m_raw[55] = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_ready && !done) begin
      chk(cpu_irq === e_irq, irq_tag, 64'(cpu_irq), 64'(e_irq));
      chk(rsp_valid === e_valid, "R10", 64'(rsp_valid), 64'(e_valid));
      if (e_valid) begin
        chk(rsp_rdata === e_data, e_tag, rsp_rdata, e_data);
        chk(rsp_err === e_err, e_tag, 64'(rsp_err), 64'(e_err));
      end
    end
  end

  task automatic access(input logic wr, input logic [11:0] a, input logic [63:0] d, input logic [2:0] sz);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [11:0] pick_addr(input int unsigned r);
    case (r % 12)
      0: return 12'h200;  1: return 12'h240;  2: return 12'h600;  3: return 12'h640;
      4: return 12'h280;  5: return 12'h2C0;  6: return 12'h680;  7: return 12'h6C0;
      8: return 12'h300;  9: return 12'h208;  10: return 12'h340;
      default: return 12'h000;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    // R9: reset state visible through reads
    access(0, 12'h300, '0, 3);
    access(0, 12'h200, '0, 3);
    // R3: program masks
    access(1, 12'h200, 64'h0000_0000_0000_00FF, 3);
    access(1, 12'h240, 64'hFFFF_0000_0000_0000, 3);
    access(1, 12'h600, '1, 3);
    access(1, 12'h640, 64'h0080_0000_0000_0000, 3);
    // R1/R2: line patterns
    dev_lines = 64'h10; idle(3);
    dev_lines = 64'h8000_0000_0000_0000; idle(3);
    dev_lines = '0; legacy_cascade = 1; idle(3);          // R6
    access(0, 12'h300, '0, 3);
    dev_lines = 64'h0080_0000_0000_0001; legacy_cascade = 0; idle(2);
    // R4: masked views
    access(0, 12'h280, '0, 3);
    access(0, 12'h2C0, '0, 3);
    access(0, 12'h680, '0, 3);
    access(0, 12'h6C0, '0, 3);
    // R5: writes to read-only registers ignored
    access(1, 12'h300, '0, 3);
    access(1, 12'h280, '0, 3);
    access(0, 12'h300, '0, 3);
    access(0, 12'h200, '0, 3);
    // R7: undersized write rejected
    access(1, 12'h200, 64'hDEAD, 2);
    access(0, 12'h200, '0, 3);
    access(0, 12'h200, '0, 0);
    // R8: unmapped offsets
    access(0, 12'h208, '0, 3);
    access(1, 12'h100, '1, 3);
    access(0, 12'h640, '0, 3);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      dev_lines = {$urandom, $urandom} & {$urandom, $urandom};
      legacy_cascade = ($urandom % 4) == 0;
      access(($urandom % 2) == 1, pick_addr($urandom),
             {$urandom, $urandom}, (($urandom % 8) == 0) ? 3'd1 : 3'd3);
    end
    idle(3);
    // R9: reset again clears everything
    rst_n = 0; idle(3); rst_n = 1;
    access(0, 12'h600, '0, 3);
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule